// File: doc/BRIEF.md
# Protected Range Cache Policy Selector

This block decides, for every processor memory access, whether the access is served uncacheable (every access goes straight to the memory controller) or write-back (the cache is used as far as possible). The decision combines three sources: a small policy table with one entry per address region, a protected range described by a base/mask register pair with its own policy, and whether the processor is currently in its privileged mode.

Any software may rewrite the policy of one region in the table. Only privileged code may load the protected range register. Outside the privileged mode, an access that falls in the protected range is always resolved as uncacheable, whatever the table holds. Untrusted code therefore cannot get protected memory into the cache and poison it. In the privileged mode, such an access takes the policy stored with the range. All other accesses take the table entry selected by the upper address bits.

The policy is computed combinationally from the access and the current state. It is registered together with the access, so a result appears one cycle after the request.

Top module: `prc_cache_policy_top`

## Requirements
- R1: After reset, every table entry holds uncacheable, the protected range is disabled and `res_valid` is 0. Policy encoding on every port is 0 = uncacheable, 1 = write-back.
- R2: An access outside the protected range resolves to the table entry whose index is the upper REGION_BITS bits of the address (bits ADDR_W-1 down to ADDR_W-REGION_BITS).
- R3: A table write takes effect from the next cycle and changes only the entry at `tbl_idx`.
- R4: An access hits the protected range when matching is enabled and (address AND mask) equals (base AND mask). A hit made with `acc_priv` = 0 resolves to uncacheable.
- R5: A hit made with `acc_priv` = 1 resolves to the policy stored in the range register.
- R6: A range register write with `acc_priv` = 0 is ignored. Base, mask, enable and policy keep their previous values.
- R7: With the range enable bit cleared, no address hits the range, even one that equals the base, and the table policy applies.
- R8: `res_valid`, `res_addr` and `res_pol` show the access presented one cycle earlier. `res_valid` is 0 after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access physical address |
| acc_priv | input | 1 | Processor is in privileged mode |
| rr_wr | input | 1 | Range register write strobe |
| rr_base | input | ADDR_W | New range base |
| rr_mask | input | ADDR_W | New range mask |
| rr_match_en | input | 1 | New range enable bit |
| rr_pol | input | 1 | New policy for range hits in privileged mode |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | REGION_BITS | Table entry to write |
| tbl_pol | input | 1 | Policy written to the entry |
| res_valid | output | 1 | Registered access valid |
| res_addr | output | ADDR_W | Registered access address |
| res_pol | output | 1 | Resolved policy for that access |

## Verification
All block state lives in the table and the range register, and both are read on every access. A wrong table entry therefore shows as a wrong `res_pol` one cycle after any access to that region. A range register that is corrupted or written without privilege shows the same way, on the first access in or near the range. The bench sweeps every address of a small configuration in both modes after each change of state, so such an error is seen within one sweep of the change. It also catches a write that spills into a neighbouring region, a match that ignores the enable bit, and a leak of write-back into unprivileged hits.

// File: rtl/prc_pkg.sv
package prc_pkg;
   typedef enum logic {
      POL_UC = 1'b0,
      POL_WB = 1'b1
   } cpol_e;
endpackage

// File: rtl/prc_region_table.sv
module prc_region_table
   import prc_pkg::*;
#(
   parameter int    REGION_BITS = 3,
   parameter cpol_e RESET_POL   = POL_UC
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REGION_BITS-1:0] wr_idx,
   input  cpol_e                  wr_pol,
   input  logic [REGION_BITS-1:0] rd_idx,
   output cpol_e                  rd_pol
);
   localparam int NREG = 1 << REGION_BITS;

   logic [NREG-1:0] pol_q;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            pol_q[gi] <= RESET_POL;
         else if (wr_en && (wr_idx == REGION_BITS'(gi)))
            pol_q[gi] <= wr_pol;
      end
   end

   assign rd_pol = cpol_e'(pol_q[rd_idx]);

   // R3: a write never disturbs more than one entry
   p_one_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pol_q ^ $past(pol_q)) <= 1);
endmodule

// File: rtl/prc_range_guard.sv
module prc_range_guard
   import prc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic              wr_match_en,
   input  cpol_e             wr_pol,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output cpol_e             hit_pol
);
   logic [ADDR_W-1:0] base_q, mask_q;
   logic              en_q;
   cpol_e             pol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         en_q   <= 1'b0;
         pol_q  <= POL_UC;
      end else if (wr_en && priv) begin
         base_q <= wr_base;
         mask_q <= wr_mask;
         en_q   <= wr_match_en;
         pol_q  <= wr_pol;
      end
   end

   assign hit     = en_q && ((addr & mask_q) == (base_q & mask_q));
   assign hit_pol = pol_q;

   // R6: without privilege the range register is frozen
   p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(priv) && $past(wr_en)) |->
         ($stable(base_q) && $stable(mask_q) && $stable(en_q) && $stable(pol_q)));

   // R7: a disabled range never reports a hit
   p_no_hit_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !hit);
endmodule

// File: rtl/prc_policy_resolve.sv
module prc_policy_resolve
   import prc_pkg::*;
(
   input  logic  priv,
   input  logic  hit,
   input  cpol_e range_pol,
   input  cpol_e table_pol,
   output cpol_e pol
);
   always_comb begin
      if (!hit)
         pol = table_pol;
      else if (priv)
         pol = range_pol;
      else
         pol = POL_UC;
   end
endmodule

// File: rtl/prc_cache_policy_top.sv
module prc_cache_policy_top
   import prc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int REGION_BITS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_valid,
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic                   acc_priv,
   input  logic                   rr_wr,
   input  logic [ADDR_W-1:0]      rr_base,
   input  logic [ADDR_W-1:0]      rr_mask,
   input  logic                   rr_match_en,
   input  logic                   rr_pol,
   input  logic                   tbl_wr,
   input  logic [REGION_BITS-1:0] tbl_idx,
   input  logic                   tbl_pol,
   output logic                   res_valid,
   output logic [ADDR_W-1:0]      res_addr,
   output logic                   res_pol
);
   localparam int IDX_LSB = ADDR_W - REGION_BITS;

   if (REGION_BITS < 1 || REGION_BITS > ADDR_W) begin : g_bad_regions
      $error("REGION_BITS must lie between 1 and ADDR_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [REGION_BITS-1:0] rd_idx;
   cpol_e                  tbl_rd_pol, rng_pol, res_pol_d;
   logic                   rng_hit;

   assign rd_idx = acc_addr[ADDR_W-1:IDX_LSB];

   prc_region_table #(.REGION_BITS(REGION_BITS), .RESET_POL(POL_UC)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr),
      .wr_idx (tbl_idx),
      .wr_pol (cpol_e'(tbl_pol)),
      .rd_idx (rd_idx),
      .rd_pol (tbl_rd_pol)
   );

   prc_range_guard #(.ADDR_W(ADDR_W)) u_range (
      .clk         (clk),
      .rst_n       (rst_n),
      .priv        (acc_priv),
      .wr_en       (rr_wr),
      .wr_base     (rr_base),
      .wr_mask     (rr_mask),
      .wr_match_en (rr_match_en),
      .wr_pol      (cpol_e'(rr_pol)),
      .addr        (acc_addr),
      .hit         (rng_hit),
      .hit_pol     (rng_pol)
   );

   prc_policy_resolve u_resolve (
      .priv      (acc_priv),
      .hit       (rng_hit),
      .range_pol (rng_pol),
      .table_pol (tbl_rd_pol),
      .pol       (res_pol_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_pol   <= POL_UC;
      end else begin
         res_valid <= acc_valid;
         if (acc_valid) begin
            res_addr <= acc_addr;
            res_pol  <= res_pol_d;
         end
      end
   end

   // R4: unprivileged hit never leaves as write-back
   p_unpriv_hit_uc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_priv && rng_hit) |=> (res_pol == POL_UC));

   // R5: privileged hit carries the range policy
   p_priv_hit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_priv && rng_hit) |=> (res_pol == $past(rng_pol)));

   // R2: a miss carries the table entry
   p_miss_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !rng_hit) |=> (res_pol == $past(tbl_rd_pol)));

   // R8: address travels with the access
   p_addr_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (res_valid && res_addr == $past(acc_addr)));
endmodule

// File: tb/prc_cache_policy_top_bench.sv
`timescale 1ns/1ps
module prc_cache_policy_top_bench;
   localparam int AW = 10;
   localparam int RB = 2;
   localparam int NR = 1 << RB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_priv = 1'b0;
   logic          rr_wr = 1'b0;
   logic [AW-1:0] rr_base = '0;
   logic [AW-1:0] rr_mask = '0;
   logic          rr_match_en = 1'b0;
   logic          rr_pol = 1'b0;
   logic          tbl_wr = 1'b0;
   logic [RB-1:0] tbl_idx = '0;
   logic          tbl_pol = 1'b0;
   logic          res_valid;
   logic [AW-1:0] res_addr;
   logic          res_pol;

   always #2.5 clk = ~clk;

   prc_cache_policy_top #(.ADDR_W(AW), .REGION_BITS(RB)) u_prc_cache_policy_top (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_priv(acc_priv), .rr_wr(rr_wr), .rr_base(rr_base), .rr_mask(rr_mask),
      .rr_match_en(rr_match_en), .rr_pol(rr_pol), .tbl_wr(tbl_wr),
      .tbl_idx(tbl_idx), .tbl_pol(tbl_pol), .res_valid(res_valid),
      .res_addr(res_addr), .res_pol(res_pol));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state, kept from the requirements only
   bit          m_tbl [NR];
   logic [AW-1:0] m_base = '0, m_mask = '0;
   bit          m_en = 0, m_pol = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit expect_pol(input logic [AW-1:0] a, input bit priv);
      if (m_en && ((a & m_mask) == (m_base & m_mask)))
         return priv ? m_pol : 1'b0;
      return m_tbl[a[AW-1:AW-RB]];
   endfunction

   task automatic access(input string tag, input logic [AW-1:0] a, input bit priv);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_priv = priv;
      @(posedge clk); #1;
      chk({tag, " pol"}, res_pol, expect_pol(a, priv));
      if (!res_valid || res_addr != a)
         chk("R8 addr/valid", {res_valid, res_addr}, {1'b1, a});
   endtask

   task automatic sweep(input string tag);
      for (int p = 0; p < 2; p++)
         for (int a = 0; a < (1 << AW); a++)
            access(tag, AW'(a), p[0]);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic tbl_write(input int idx, input bit pol);
      @(negedge clk);
      acc_valid = 1'b0; tbl_wr = 1'b1; tbl_idx = RB'(idx); tbl_pol = pol;
      @(negedge clk);
      tbl_wr = 1'b0;
      m_tbl[idx] = pol;
   endtask

   task automatic rr_write(input bit priv, input logic [AW-1:0] b,
                           input logic [AW-1:0] m, input bit en, input bit pol);
      @(negedge clk);
      acc_valid = 1'b0; acc_priv = priv;
      rr_wr = 1'b1; rr_base = b; rr_mask = m; rr_match_en = en; rr_pol = pol;
      @(negedge clk);
      rr_wr = 1'b0; acc_priv = 1'b0;
      if (priv) begin
         m_base = b; m_mask = m; m_en = en; m_pol = pol;
      end
   endtask

   initial begin
      for (int i = 0; i < NR; i++) m_tbl[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 res_valid after reset", res_valid, 0);
      sweep("R1 reset state");

      // R3: one entry at a time; probe every region after each write
      for (int i = 0; i < NR; i++) begin
         tbl_write(i, (i != 1));
         for (int r = 0; r < NR; r++)
            access("R3 single region", AW'(r << (AW - RB)) | AW'(5), 1'b0);
      end
      sweep("R2 table lookup");

      // R6: unprivileged range write must be ignored
      rr_write(1'b0, AW'('h140), AW'('h3C0), 1'b1, 1'b1);
      sweep("R6 locked range");

      // R4/R5: range in a UC region with WB range policy
      rr_write(1'b1, AW'('h140), AW'('h3C0), 1'b1, 1'b1);
      sweep("R4 R5 range WB");

      // range in a WB region with UC range policy, sparse mask
      rr_write(1'b1, AW'('h2C4), AW'('h3C4), 1'b1, 1'b0);
      sweep("R4 R5 range UC");

      // R7: matching disabled
      rr_write(1'b1, AW'('h2C4), AW'('h3C4), 1'b0, 1'b1);
      access("R7 base addr", AW'('h2C4), 1'b0);
      access("R7 base addr", AW'('h2C4), 1'b1);
      sweep("R7 disabled range");

      // R8: idle cycle clears res_valid
      @(negedge clk);
      acc_valid = 1'b0;
      @(posedge clk); #1;
      chk("R8 idle valid", res_valid, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule